// File: doc/BRIEF.md
# Queue-Port Messaging Unit

This block sits between a host-side register slave and an embedded I/O processor and carries all traffic between them. The host sees a small 32-bit register window. It holds message registers in each direction, a doorbell, two status/mask pairs and two queue ports. The processor sees push/pop handshakes on three hardware FIFOs, plus direct views of the inbound message and doorbell registers.

Reading or writing a queue-port address has a different effect, and each access is a FIFO operation.

- **Inbound port, read:** pops a free request token, which is an offset into processor memory.
- **Inbound port, write:** posts a request to the processor.
- **Outbound port, read:** pops a completion token.
- **Outbound port, write:** hands a processor-memory request back to the free pool.

A posted token with its top bit set names a request in host memory. Its lower 31 bits are the 32-byte-aligned bus address divided by 32. For requests that carry an output context, the processor chooses the completion token (for example the low 32 bits of that context), and the block passes it through unchanged.

Non-queued commands are written to inbound message 0. The processor signals completion by writing the same value back to outbound message 0, which raises a dedicated echo status bit.

Top module: `qport_msg_unit`

## Requirements
- R1: After reset, every message, doorbell, status and mask register reads 0, both interrupt outputs are low and all FIFOs are empty.
- R2: Host registers sit at these byte offsets: 0x10/0x14 inbound message 0/1, 0x18/0x1C outbound message 0/1 (read-only), 0x20 doorbell, 0x24 inbound status (read-only to host), 0x28 inbound mask, 0x30 outbound status, 0x34 outbound mask, 0x40 inbound queue port, 0x44 outbound queue port. Read data appears on the cycle after the read strobe and is held until the next read.
- R3: The processor fills the free FIFO through a valid/ready push. A host read of 0x40 pops it in first-in order. A read while it is empty returns 0xFFFFFFFF and removes nothing.
- R4: A host write to 0x40 posts the token to the processor in first-in order, popped with a valid/ready handshake. The post-side flag output equals token bit 31. The post-side bus address output equals token bits 30:0 shifted left by 5.
- R5: A processor completion push sets outbound status bit 3. A host read of 0x44 pops completions in order and returns 0xFFFFFFFF when none are queued.
- R6: A host write to 0x44 pushes the token into the free FIFO. In that cycle the processor's free-push ready is low, so the host return wins.
- R7: A host write of inbound message 0 or 1 sets inbound status bit 0 or 1. A processor write of outbound message 0 or 1 sets outbound status bit 0 or 1. A processor write to outbound message 0 whose value equals the current inbound message 0 also sets outbound status bit 2.
- R8: A host push (0x40 or 0x44 write) into a full FIFO is dropped and sets outbound status bit 4. The entries already queued are unchanged.
- R9: The host interrupt is high exactly when some outbound status bit is set while its mask bit is 0. Writing 1s to 0x30 clears those status bits, and a set in the same cycle wins over the clear.
- R10: Doorbell writes OR into the doorbell register, and a nonzero write sets inbound status bit 2. The processor interrupt is the OR of inbound status bits whose mask bit is 0. The processor clears inbound status and doorbell bits by write-1-to-clear inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostRdEn | input | 1 | Host register read strobe |
| hostAddr | input | ADDR_W | Host byte offset |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data, one cycle after the strobe |
| hostIrq | output | 1 | Host interrupt |
| cpuFreeValid | input | 1 | Processor offers a free token |
| cpuFreeData | input | 32 | Free token |
| cpuFreeReady | output | 1 | Free token accepted |
| cpuPostValid | output | 1 | Posted request available |
| cpuPostData | output | 32 | Posted request token |
| cpuPostHost | output | 1 | Token names a host-memory request |
| cpuPostAddr | output | 36 | Decoded host bus address |
| cpuPostReady | input | 1 | Processor pops posted request |
| cpuDoneValid | input | 1 | Processor offers a completion |
| cpuDoneData | input | 32 | Completion token |
| cpuDoneReady | output | 1 | Completion accepted |
| cpuMsgWr | input | 1 | Processor writes an outbound message |
| cpuMsgSel | input | 1 | Outbound message select (0 or 1) |
| cpuMsgData | input | 32 | Outbound message value |
| cpuInMsg0 | output | 32 | Inbound message 0 |
| cpuInMsg1 | output | 32 | Inbound message 1 |
| cpuBell | output | 32 | Doorbell bits |
| cpuInStat | output | 3 | Inbound status bits |
| cpuInClr | input | 3 | Write-1-to-clear for inbound status |
| cpuBellClr | input | 32 | Write-1-to-clear for doorbell |
| cpuIrq | output | 1 | Processor interrupt |

## Verification
A corrupted FIFO pointer shows on the very next queue-port read or post handshake. The token comes out in the wrong order, twice, or as 0xFFFFFFFF while entries remain. A status bit stuck high or dropped shows in the same cycle as a wrong interrupt level, and on the next read of the status offset. A wrong echo comparison or overflow latch appears in the status word read one cycle after the triggering event. A lost doorbell bit is visible on the doorbell output immediately after the write edge.

// File: rtl/qpu_pkg.sv
package qpu_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned OUT_ST_W  = 5;
  localparam int unsigned IN_ST_W   = 3;
  localparam int unsigned ALIGN_SH  = 5;
  localparam int unsigned BUS_AW    = DATA_W - 1 + ALIGN_SH;

  localparam int unsigned OFS_IM0   = 'h10;
  localparam int unsigned OFS_IM1   = 'h14;
  localparam int unsigned OFS_OM0   = 'h18;
  localparam int unsigned OFS_OM1   = 'h1C;
  localparam int unsigned OFS_BELL  = 'h20;
  localparam int unsigned OFS_INST  = 'h24;
  localparam int unsigned OFS_INMSK = 'h28;
  localparam int unsigned OFS_OUTST = 'h30;
  localparam int unsigned OFS_OUTMK = 'h34;
  localparam int unsigned OFS_INQ   = 'h40;
  localparam int unsigned OFS_OUTQ  = 'h44;

  // outbound status bit positions
  localparam int unsigned OST_OM0  = 0;
  localparam int unsigned OST_OM1  = 1;
  localparam int unsigned OST_ECHO = 2;
  localparam int unsigned OST_DONE = 3;
  localparam int unsigned OST_OVFL = 4;

  // inbound status bit positions
  localparam int unsigned IST_IM0  = 0;
  localparam int unsigned IST_IM1  = 1;
  localparam int unsigned IST_BELL = 2;

  typedef enum logic [3:0] {
    SEL_IM0, SEL_IM1, SEL_OM0, SEL_OM1, SEL_BELL, SEL_INSTAT,
    SEL_INMASK, SEL_OUTSTAT, SEL_OUTMASK, SEL_FREEQ, SEL_DONEQ, SEL_NONE
  } rdSel_e;

  typedef struct packed {
    logic   rd;
    rdSel_e rdSel;
    logic   wrInMsg0;
    logic   wrInMsg1;
    logic   wrBell;
    logic   wrInMask;
    logic   wrOutStat;
    logic   wrOutMask;
    logic   pushPost;
    logic   pushFree;
    logic   popFree;
    logic   popDone;
  } hostStrobe_t;
endpackage

// File: rtl/qpu_fifo.sv
module qpu_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popEn,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [CW-1:0] wrPtr, rdPtr, count;
  logic doPush, doPop;

  assign count    = wrPtr - rdPtr;
  assign empty    = (count == '0);
  assign full     = (count == FULL_CNT);
  assign doPush   = pushEn && !full;
  assign doPop    = popEn && !empty;
  assign headData = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + CW'(1);
      if (doPop)  rdPtr <= rdPtr + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr[AW-1:0]] <= pushData;
  end

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R3
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && empty) |=> $stable(rdPtr));
endmodule

// File: rtl/qpu_ctrl.sv
module qpu_ctrl import qpu_pkg::*; #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              freeEmpty,
  input  logic              doneEmpty,
  output hostStrobe_t       hs
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    hs       = '0;
    hs.rdSel = SEL_NONE;
    if (hostRdEn) begin
      hs.rd = 1'b1;
      case (hostAddr)
        ADDR_W'(OFS_IM0):   hs.rdSel = SEL_IM0;
        ADDR_W'(OFS_IM1):   hs.rdSel = SEL_IM1;
        ADDR_W'(OFS_OM0):   hs.rdSel = SEL_OM0;
        ADDR_W'(OFS_OM1):   hs.rdSel = SEL_OM1;
        ADDR_W'(OFS_BELL):  hs.rdSel = SEL_BELL;
        ADDR_W'(OFS_INST):  hs.rdSel = SEL_INSTAT;
        ADDR_W'(OFS_INMSK): hs.rdSel = SEL_INMASK;
        ADDR_W'(OFS_OUTST): hs.rdSel = SEL_OUTSTAT;
        ADDR_W'(OFS_OUTMK): hs.rdSel = SEL_OUTMASK;
        ADDR_W'(OFS_INQ): begin
          hs.rdSel   = SEL_FREEQ;
          hs.popFree = !freeEmpty;
        end
        ADDR_W'(OFS_OUTQ): begin
          hs.rdSel   = SEL_DONEQ;
          hs.popDone = !doneEmpty;
        end
        default:            hs.rdSel = SEL_NONE;
      endcase
    end
    if (hostWrEn) begin
      case (hostAddr)
        ADDR_W'(OFS_IM0):   hs.wrInMsg0  = 1'b1;
        ADDR_W'(OFS_IM1):   hs.wrInMsg1  = 1'b1;
        ADDR_W'(OFS_BELL):  hs.wrBell    = 1'b1;
        ADDR_W'(OFS_INMSK): hs.wrInMask  = 1'b1;
        ADDR_W'(OFS_OUTST): hs.wrOutStat = 1'b1;
        ADDR_W'(OFS_OUTMK): hs.wrOutMask = 1'b1;
        ADDR_W'(OFS_INQ):   hs.pushPost  = 1'b1;
        ADDR_W'(OFS_OUTQ):  hs.pushFree  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/qpu_datapath.sv
module qpu_datapath import qpu_pkg::*; #(
  parameter int unsigned FREE_DEPTH = 8,
  parameter int unsigned POST_DEPTH = 8,
  parameter int unsigned DONE_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  hostStrobe_t         hs,
  input  logic [DATA_W-1:0]   hostWrData,
  output logic [DATA_W-1:0]   hostRdData,
  output logic                hostIrq,
  output logic                freeEmpty,
  output logic                doneEmpty,
  input  logic                cpuFreeValid,
  input  logic [DATA_W-1:0]   cpuFreeData,
  output logic                cpuFreeReady,
  output logic                cpuPostValid,
  output logic [DATA_W-1:0]   cpuPostData,
  output logic                cpuPostHost,
  output logic [BUS_AW-1:0]   cpuPostAddr,
  input  logic                cpuPostReady,
  input  logic                cpuDoneValid,
  input  logic [DATA_W-1:0]   cpuDoneData,
  output logic                cpuDoneReady,
  input  logic                cpuMsgWr,
  input  logic                cpuMsgSel,
  input  logic [DATA_W-1:0]   cpuMsgData,
  output logic [DATA_W-1:0]   cpuInMsg0,
  output logic [DATA_W-1:0]   cpuInMsg1,
  output logic [DATA_W-1:0]   cpuBell,
  output logic [IN_ST_W-1:0]  cpuInStat,
  input  logic [IN_ST_W-1:0]  cpuInClr,
  input  logic [DATA_W-1:0]   cpuBellClr,
  output logic                cpuIrq
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DATA_W-1:0]   inMsg0, inMsg1, outMsg0, outMsg1, bell;
  logic [IN_ST_W-1:0]  inStat, inMask, inSet;
  logic [OUT_ST_W-1:0] outStat, outMask, outSet, outClr;
  logic [DATA_W-1:0]   freeHead, postHead, doneHead, freePushData, rdNext;
  logic freeFull, postFull, doneFull, postEmpty;
  logic freePushEn, donePush, postPop;

  // free pool: host return has priority over processor refill
  assign cpuFreeReady = !freeFull && !hs.pushFree;
  assign freePushEn   = hs.pushFree || (cpuFreeValid && cpuFreeReady);
  assign freePushData = hs.pushFree ? hostWrData : cpuFreeData;

  qpu_fifo #(.WIDTH(DATA_W), .DEPTH(FREE_DEPTH)) freeQ (
    .clk(clk), .rstN(rstN), .pushEn(freePushEn), .pushData(freePushData),
    .popEn(hs.popFree), .headData(freeHead), .empty(freeEmpty), .full(freeFull));

  assign postPop = cpuPostReady && !postEmpty;

  qpu_fifo #(.WIDTH(DATA_W), .DEPTH(POST_DEPTH)) postQ (
    .clk(clk), .rstN(rstN), .pushEn(hs.pushPost), .pushData(hostWrData),
    .popEn(postPop), .headData(postHead), .empty(postEmpty), .full(postFull));

  assign cpuPostValid = !postEmpty;
  assign cpuPostData  = postHead;
  assign cpuPostHost  = postHead[DATA_W-1];
  assign cpuPostAddr  = {postHead[DATA_W-2:0], {ALIGN_SH{1'b0}}};

  assign cpuDoneReady = !doneFull;
  assign donePush     = cpuDoneValid && cpuDoneReady;

  qpu_fifo #(.WIDTH(DATA_W), .DEPTH(DONE_DEPTH)) doneQ (
    .clk(clk), .rstN(rstN), .pushEn(donePush), .pushData(cpuDoneData),
    .popEn(hs.popDone), .headData(doneHead), .empty(doneEmpty), .full(doneFull));

  // status event collection
  always_comb begin
    outSet = '0;
    outSet[OST_OM0]  = cpuMsgWr && !cpuMsgSel;
    outSet[OST_OM1]  = cpuMsgWr && cpuMsgSel;
    outSet[OST_ECHO] = cpuMsgWr && !cpuMsgSel && (cpuMsgData == inMsg0);
    outSet[OST_DONE] = donePush;
    outSet[OST_OVFL] = (hs.pushPost && postFull) || (hs.pushFree && freeFull);
    outClr = hs.wrOutStat ? hostWrData[OUT_ST_W-1:0] : '0;
    inSet = '0;
    inSet[IST_IM0]  = hs.wrInMsg0;
    inSet[IST_IM1]  = hs.wrInMsg1;
    inSet[IST_BELL] = hs.wrBell && (hostWrData != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inMsg0  <= '0;
      inMsg1  <= '0;
      outMsg0 <= '0;
      outMsg1 <= '0;
      bell    <= '0;
      inStat  <= '0;
      inMask  <= '0;
      outStat <= '0;
      outMask <= '0;
    end else begin
      if (hs.wrInMsg0) inMsg0 <= hostWrData;
      if (hs.wrInMsg1) inMsg1 <= hostWrData;
      if (cpuMsgWr && !cpuMsgSel) outMsg0 <= cpuMsgData;
      if (cpuMsgWr && cpuMsgSel)  outMsg1 <= cpuMsgData;
      bell    <= (bell & ~cpuBellClr) | (hs.wrBell ? hostWrData : '0);
      inStat  <= (inStat & ~cpuInClr) | inSet;
      outStat <= (outStat & ~outClr) | outSet;
      if (hs.wrInMask)  inMask  <= hostWrData[IN_ST_W-1:0];
      if (hs.wrOutMask) outMask <= hostWrData[OUT_ST_W-1:0];
    end
  end

  assign hostIrq   = |(outStat & ~outMask);
  assign cpuIrq    = |(inStat & ~inMask);
  assign cpuInMsg0 = inMsg0;
  assign cpuInMsg1 = inMsg1;
  assign cpuBell   = bell;
  assign cpuInStat = inStat;

  always_comb begin
    case (hs.rdSel)
      SEL_IM0:     rdNext = inMsg0;
      SEL_IM1:     rdNext = inMsg1;
      SEL_OM0:     rdNext = outMsg0;
      SEL_OM1:     rdNext = outMsg1;
      SEL_BELL:    rdNext = bell;
      SEL_INSTAT:  rdNext = DATA_W'(inStat);
      SEL_INMASK:  rdNext = DATA_W'(inMask);
      SEL_OUTSTAT: rdNext = DATA_W'(outStat);
      SEL_OUTMASK: rdNext = DATA_W'(outMask);
      SEL_FREEQ:   rdNext = freeEmpty ? '1 : freeHead;
      SEL_DONEQ:   rdNext = doneEmpty ? '1 : doneHead;
      default:     rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)      hostRdData <= '0;
    else if (hs.rd) hostRdData <= rdNext;
  end

  // R3
  empty_read_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hs.rd && hs.rdSel == SEL_FREEQ && freeEmpty) |=> (hostRdData == '1));

  // R5
  done_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuDoneValid && cpuDoneReady) |=> outStat[OST_DONE]);

  // R7
  echo_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuMsgWr && !cpuMsgSel && cpuMsgData == inMsg0) |=> outStat[OST_ECHO]);

  // R8
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hs.pushPost && postFull) |=> outStat[OST_OVFL]);
endmodule

// File: rtl/qport_msg_unit.sv
module qport_msg_unit import qpu_pkg::*; #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned FREE_DEPTH = 8,
  parameter int unsigned POST_DEPTH = 8,
  parameter int unsigned DONE_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWrEn,
  input  logic                hostRdEn,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [31:0]         hostWrData,
  output logic [31:0]         hostRdData,
  output logic                hostIrq,
  input  logic                cpuFreeValid,
  input  logic [31:0]         cpuFreeData,
  output logic                cpuFreeReady,
  output logic                cpuPostValid,
  output logic [31:0]         cpuPostData,
  output logic                cpuPostHost,
  output logic [35:0]         cpuPostAddr,
  input  logic                cpuPostReady,
  input  logic                cpuDoneValid,
  input  logic [31:0]         cpuDoneData,
  output logic                cpuDoneReady,
  input  logic                cpuMsgWr,
  input  logic                cpuMsgSel,
  input  logic [31:0]         cpuMsgData,
  output logic [31:0]         cpuInMsg0,
  output logic [31:0]         cpuInMsg1,
  output logic [31:0]         cpuBell,
  output logic [2:0]          cpuInStat,
  input  logic [2:0]          cpuInClr,
  input  logic [31:0]         cpuBellClr,
  output logic                cpuIrq
);
  timeunit 1ns;
  timeprecision 1ps;

  hostStrobe_t hs;
  logic freeEmpty, doneEmpty;

  qpu_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
    .freeEmpty(freeEmpty), .doneEmpty(doneEmpty), .hs(hs));

  qpu_datapath #(.FREE_DEPTH(FREE_DEPTH), .POST_DEPTH(POST_DEPTH),
                 .DONE_DEPTH(DONE_DEPTH)) dp (
    .clk(clk), .rstN(rstN), .hs(hs), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .hostIrq(hostIrq),
    .freeEmpty(freeEmpty), .doneEmpty(doneEmpty),
    .cpuFreeValid(cpuFreeValid), .cpuFreeData(cpuFreeData), .cpuFreeReady(cpuFreeReady),
    .cpuPostValid(cpuPostValid), .cpuPostData(cpuPostData), .cpuPostHost(cpuPostHost),
    .cpuPostAddr(cpuPostAddr), .cpuPostReady(cpuPostReady),
    .cpuDoneValid(cpuDoneValid), .cpuDoneData(cpuDoneData), .cpuDoneReady(cpuDoneReady),
    .cpuMsgWr(cpuMsgWr), .cpuMsgSel(cpuMsgSel), .cpuMsgData(cpuMsgData),
    .cpuInMsg0(cpuInMsg0), .cpuInMsg1(cpuInMsg1), .cpuBell(cpuBell),
    .cpuInStat(cpuInStat), .cpuInClr(cpuInClr), .cpuBellClr(cpuBellClr),
    .cpuIrq(cpuIrq));
endmodule

// File: tb/tb_qport_msg_unit.sv
module tb_qport_msg_unit;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [7:0] hostAddr = '0;
  logic [31:0] hostWrData = '0, hostRdData;
  logic hostIrq;
  logic cpuFreeValid = 1'b0;
  logic [31:0] cpuFreeData = '0;
  logic cpuFreeReady, cpuPostValid, cpuPostHost;
  logic [31:0] cpuPostData;
  logic [35:0] cpuPostAddr;
  logic cpuPostReady = 1'b0;
  logic cpuDoneValid = 1'b0;
  logic [31:0] cpuDoneData = '0;
  logic cpuDoneReady;
  logic cpuMsgWr = 1'b0, cpuMsgSel = 1'b0;
  logic [31:0] cpuMsgData = '0;
  logic [31:0] cpuInMsg0, cpuInMsg1, cpuBell;
  logic [2:0] cpuInStat;
  logic [2:0] cpuInClr = '0;
  logic [31:0] cpuBellClr = '0;
  logic cpuIrq;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  qport_msg_unit dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    hostRdEn = 1'b1; hostAddr = a;
    @(posedge clk); #1;
    hostRdEn = 1'b0;
    d = hostRdData;
  endtask

  task automatic cpuFree(input logic [31:0] d);
    @(negedge clk);
    cpuFreeValid = 1'b1; cpuFreeData = d;
    @(posedge clk); #1;
    cpuFreeValid = 1'b0;
  endtask

  task automatic cpuDone(input logic [31:0] d);
    @(negedge clk);
    cpuDoneValid = 1'b1; cpuDoneData = d;
    @(posedge clk); #1;
    cpuDoneValid = 1'b0;
  endtask

  task automatic cpuPop();
    @(negedge clk);
    cpuPostReady = 1'b1;
    @(posedge clk); #1;
    cpuPostReady = 1'b0;
  endtask

  task automatic cpuMsg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cpuMsgWr = 1'b1; cpuMsgSel = sel; cpuMsgData = d;
    @(posedge clk); #1;
    cpuMsgWr = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    chk("R1 hostIrq", 64'(hostIrq), 64'd0);
    chk("R1 cpuIrq", 64'(cpuIrq), 64'd0);
    chk("R1 postValid", 64'(cpuPostValid), 64'd0);
    hostRead(8'h30, v); chk("R1 outStat", 64'(v), 64'd0);
    hostRead(8'h24, v); chk("R1 inStat", 64'(v), 64'd0);
    hostRead(8'h10, v); chk("R1 inMsg0", 64'(v), 64'd0);
    hostRead(8'h44, v); chk("R5 empty done read", 64'(v), 64'hFFFF_FFFF);
  endtask

  task automatic testFree();
    logic [31:0] v;
    cpuFree(32'h100); cpuFree(32'h200); cpuFree(32'h300);
    hostRead(8'h40, v); chk("R3 free pop 1", 64'(v), 64'h100);
    hostRead(8'h40, v); chk("R3 free pop 2", 64'(v), 64'h200);
    hostRead(8'h40, v); chk("R3 free pop 3", 64'(v), 64'h300);
    hostRead(8'h40, v); chk("R3 empty free read", 64'(v), 64'hFFFF_FFFF);
    hostRead(8'h40, v); chk("R3 still empty", 64'(v), 64'hFFFF_FFFF);
  endtask

  task automatic testPost();
    hostWrite(8'h40, 32'h8000_0123);
    hostWrite(8'h40, 32'h0000_0400);
    chk("R4 post valid", 64'(cpuPostValid), 64'd1);
    chk("R4 post data", 64'(cpuPostData), 64'h8000_0123);
    chk("R4 host flag", 64'(cpuPostHost), 64'd1);
    chk("R4 bus addr", 64'(cpuPostAddr), 64'h2460);
    cpuPop();
    chk("R4 second data", 64'(cpuPostData), 64'h400);
    chk("R4 second flag", 64'(cpuPostHost), 64'd0);
    cpuPop();
    chk("R4 drained", 64'(cpuPostValid), 64'd0);
  endtask

  task automatic testDone();
    logic [31:0] v;
    cpuDone(32'hABC);
    chk("R9 irq on completion", 64'(hostIrq), 64'd1);
    hostRead(8'h30, v); chk("R5 done status", 64'(v), 64'h8);
    hostRead(8'h44, v); chk("R5 done pop", 64'(v), 64'hABC);
    hostRead(8'h44, v); chk("R5 done empty", 64'(v), 64'hFFFF_FFFF);
    hostWrite(8'h30, 32'h8);
    chk("R9 w1c irq", 64'(hostIrq), 64'd0);
    hostRead(8'h30, v); chk("R9 w1c status", 64'(v), 64'h0);
    hostWrite(8'h34, 32'h8);
    cpuDone(32'hDEF);
    chk("R9 masked irq", 64'(hostIrq), 64'd0);
    hostRead(8'h30, v); chk("R9 masked status", 64'(v), 64'h8);
    hostWrite(8'h34, 32'h0);
    chk("R9 unmask irq", 64'(hostIrq), 64'd1);
    hostRead(8'h44, v); chk("R5 second pop", 64'(v), 64'hDEF);
    hostWrite(8'h30, 32'h1F);
  endtask

  task automatic testReturn();
    logic [31:0] v;
    @(negedge clk);
    cpuFreeValid = 1'b1; cpuFreeData = 32'h777;
    hostWrEn = 1'b1; hostAddr = 8'h44; hostWrData = 32'h500;
    #1;
    chk("R6 cpu ready low", 64'(cpuFreeReady), 64'd0);
    @(posedge clk); #1;
    cpuFreeValid = 1'b0; hostWrEn = 1'b0;
    hostRead(8'h40, v); chk("R6 returned token", 64'(v), 64'h500);
    hostRead(8'h40, v); chk("R6 cpu token not taken", 64'(v), 64'hFFFF_FFFF);
  endtask

  task automatic testMsg();
    logic [31:0] v;
    hostWrite(8'h10, 32'h55);
    chk("R7 inMsg0 out", 64'(cpuInMsg0), 64'h55);
    chk("R7 inStat bit0", 64'(cpuInStat), 64'h1);
    chk("R10 cpuIrq", 64'(cpuIrq), 64'd1);
    cpuMsg(1'b0, 32'h55);
    hostRead(8'h30, v); chk("R7 echo status", 64'(v), 64'h5);
    hostRead(8'h18, v); chk("R2 outMsg0 read", 64'(v), 64'h55);
    hostWrite(8'h30, 32'h1F);
    cpuMsg(1'b1, 32'h66);
    hostRead(8'h30, v); chk("R7 outMsg1 status", 64'(v), 64'h2);
    hostRead(8'h1C, v); chk("R2 outMsg1 read", 64'(v), 64'h66);
    hostWrite(8'h30, 32'h1F);
    cpuMsg(1'b0, 32'h12);
    hostRead(8'h30, v); chk("R7 no echo on mismatch", 64'(v), 64'h1);
    hostWrite(8'h30, 32'h1F);
    hostWrite(8'h14, 32'h99);
    chk("R7 inMsg1 out", 64'(cpuInMsg1), 64'h99);
    chk("R7 inStat bit1", 64'(cpuInStat), 64'h3);
    @(negedge clk); cpuInClr = 3'h7; @(posedge clk); #1; cpuInClr = '0;
    hostRead(8'h24, v); chk("R10 inStat cleared", 64'(v), 64'h0);
  endtask

  task automatic testInbound();
    logic [31:0] v;
    hostWrite(8'h20, 32'h3);
    hostWrite(8'h20, 32'h4);
    chk("R10 bell accum", 64'(cpuBell), 64'h7);
    chk("R10 bell status", 64'(cpuInStat), 64'h4);
    hostRead(8'h20, v); chk("R2 bell read", 64'(v), 64'h7);
    hostWrite(8'h28, 32'h7);
    chk("R10 masked cpuIrq", 64'(cpuIrq), 64'd0);
    hostRead(8'h28, v); chk("R2 inMask read", 64'(v), 64'h7);
    @(negedge clk); cpuBellClr = 32'h1; cpuInClr = 3'h4;
    @(posedge clk); #1; cpuBellClr = '0; cpuInClr = '0;
    chk("R10 bell clear", 64'(cpuBell), 64'h6);
    hostRead(8'h24, v); chk("R10 stat clear", 64'(v), 64'h0);
    hostWrite(8'h28, 32'h0);
  endtask

  task automatic testOverflow();
    logic [31:0] v;
    for (int i = 0; i < 9; i++) hostWrite(8'h40, 32'h1000 + 32'(i));
    hostRead(8'h30, v); chk("R8 overflow status", 64'(v), 64'h10);
    chk("R9 overflow irq", 64'(hostIrq), 64'd1);
    for (int i = 0; i < 8; i++) begin
      chk("R8 kept entry", 64'(cpuPostData), 64'h1000 + 64'(i));
      cpuPop();
    end
    chk("R8 dropped push", 64'(cpuPostValid), 64'd0);
    hostWrite(8'h30, 32'h1F);
    chk("R9 clear overflow", 64'(hostIrq), 64'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testFree();
    testPost();
    testDone();
    testReturn();
    testMsg();
    testInbound();
    testOverflow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule